// File: doc/BRIEF.md
# Serial CRC-16 Framer and Checker

This block adds and checks a CRC-16 on a transparent serial link, one bit per clock. On the transmit side it takes whole bytes and puts their bits on the line one per cycle. A frame-level bit-order control picks the order: least significant bit first, or most significant bit first. Each bit is folded into the running CRC in the order it leaves, so the checksum always covers the stream as it appears on the wire. When the frame ends, the 16 CRC bits follow the data. They always go out most significant bit first, whatever the data order.

The receive side folds every incoming bit into its own CRC as soon as the bit arrives. It then assembles bytes in arrival order. If the bit-order control asks for it, each byte is bit-reversed only after the CRC has seen its bits. At the end of the frame, the residue of the receive CRC is compared against zero, and an error flag reports a mismatch.

Both sides use the polynomial x^16+x^12+x^5+1 with an all-ones preset. Frame start and frame end are plain strobes from the surrounding controller, because a transparent stream carries no delimiters of its own.

Top module: `crcser_top`

## Requirements
- R1: A frame-start strobe presets the CRC to 0xFFFF. Each folded bit b does the following: f = crc[15]^b; crc = (crc<<1) ^ (f ? 0x1021 : 0).
- R2: A byte loaded while `tx_ready` is high appears as 8 bits on `tx_bit`, with `tx_bit_valid` high on the 8 consecutive cycles right after the load. `tx_ready` is low during those cycles.
- R3: With `rev_order`=0 the data bits go out bit 0 first. With `rev_order`=1 they go out bit 7 first. The CRC folds the bits in the same order they go out.
- R4: A transmit end-of-frame strobe, given while `tx_ready` is high, sends the 16 CRC bits on 16 consecutive cycles, bit 15 first, for either value of `rev_order`.
- R5: Every 8 received bits give one byte on `rx_byte`, with `rx_byte_valid` high for one cycle after the eighth bit. With `rev_order`=0 the first received bit lands in bit 0. With `rev_order`=1 it lands in bit 7.
- R6: The receive CRC folds bits in arrival order, before any byte reversal. A frame from the transmitter therefore checks clean in either bit order.
- R7: One cycle after a receive end-of-frame strobe, `rx_crc_err` is 1 if the CRC residue is not 0x0000, and 0 if it is.
- R8: `rx_crc_err` keeps its value until the next receive frame-start strobe, which clears it.
- R9: Out of reset, `tx_ready`=1, `tx_bit_valid`=0, `rx_byte_valid`=0 and `rx_crc_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rev_order | input | 1 | 0: data bit 0 first on the wire; 1: data bit 7 first |
| tx_sof | input | 1 | Transmit frame-start strobe (presets the CRC) |
| tx_load | input | 1 | Load `tx_data` for sending; taken when `tx_ready` is high |
| tx_data | input | 8 | Byte to send |
| tx_eof | input | 1 | Transmit end-of-frame strobe; appends the CRC |
| tx_ready | output | 1 | Transmitter is idle and can take a byte or an end-of-frame strobe |
| tx_bit | output | 1 | Serial line output |
| tx_bit_valid | output | 1 | `tx_bit` carries a bit this cycle |
| rx_sof | input | 1 | Receive frame-start strobe (presets the CRC, clears the error flag) |
| rx_bit | input | 1 | Serial line input |
| rx_bit_valid | input | 1 | `rx_bit` carries a bit this cycle |
| rx_eof | input | 1 | Receive end-of-frame strobe; runs the residue check |
| rx_byte | output | 8 | Assembled received byte |
| rx_byte_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_crc_err | output | 1 | CRC residue mismatch at the last end of frame |

## Verification
The transmit line is captured bit by bit for an asymmetric byte in both bit orders. This shows whether the data order follows `rev_order` while the appended CRC keeps a fixed most-significant-first order. Multi-byte frames are looped from the transmitter into the receiver in both orders. A clean residue and matching bytes show that both CRCs fold the same wire order and that the reversal comes after the fold. A single flipped line bit must then raise the error flag, which must hold until the next frame start clears it.

// File: rtl/crcser_pkg.sv
package crcser_pkg;
  localparam int unsigned DEF_CRC_W  = 16;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam logic [15:0] DEF_POLY   = 16'h1021;
  localparam logic [15:0] DEF_PRESET = 16'hFFFF;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_CRC  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/crcser_crc_reg.sv
module crcser_crc_reg #(
  parameter int unsigned   CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;
  logic             crc_en;

  assign fb     = crc_q[CRC_W-1] ^ din;
  assign crc_en = init | step;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = PRESET;
    end else if (step) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

  // R1: a preset lands the register on the preset value
  a_r1_preset: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == PRESET));
  // R1: a step with zero feedback is a plain left shift
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !init && !(crc_q[CRC_W-1] ^ din)) |=> (crc_q[0] == 1'b0));
endmodule

// File: rtl/crcser_tx.sv
module crcser_tx
  import crcser_pkg::*;
#(
  parameter int unsigned   CRC_W  = 16,
  parameter int unsigned   BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev,
  input  logic              sof,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  logic              eof,
  output logic              ready,
  output logic              bit_o,
  output logic              valid_o
);
  localparam int unsigned MAX_W = (CRC_W > BYTE_W) ? CRC_W : BYTE_W;
  localparam int unsigned CNT_W = $clog2(MAX_W);

  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CRC_W-1:0]  csh_q, csh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rev_q, rev_d;
  logic              adv_en;
  logic              wire_bit;
  logic [CRC_W-1:0]  crc;
  logic              is_idle;

  assign is_idle = (state_q == TX_IDLE);
  assign ready   = is_idle;
  assign valid_o = !is_idle;
  assign adv_en  = !is_idle || load || eof;

  always_comb begin
    if (state_q == TX_DATA) begin
      wire_bit = rev_q ? sh_q[BYTE_W-1] : sh_q[0];
    end else begin
      wire_bit = csh_q[CRC_W-1];
    end
  end
  assign bit_o = wire_bit;

  crcser_crc_reg #(.CRC_W(CRC_W), .POLY(POLY), .PRESET(PRESET)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (sof && is_idle),
    .step (state_q == TX_DATA),
    .din  (wire_bit),
    .crc  (crc)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    csh_d   = csh_q;
    cnt_d   = cnt_q;
    rev_d   = rev_q;
    case (state_q)
      TX_IDLE: begin
        if (load) begin
          sh_d    = data;
          rev_d   = rev;
          cnt_d   = CNT_W'(BYTE_W - 1);
          state_d = TX_DATA;
        end else if (eof) begin
          csh_d   = crc;
          cnt_d   = CNT_W'(CRC_W - 1);
          state_d = TX_CRC;
        end
      end
      TX_DATA: begin
        sh_d  = rev_q ? (sh_q << 1) : (sh_q >> 1);
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == '0) state_d = TX_IDLE;
      end
      TX_CRC: begin
        csh_d = csh_q << 1;
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == '0) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      csh_q   <= '0;
      cnt_q   <= '0;
      rev_q   <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      sh_q    <= sh_d;
      csh_q   <= csh_d;
      cnt_q   <= cnt_d;
      rev_q   <= rev_d;
    end
  end

  // R2: an accepted byte starts on the line the next cycle
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready) |=> (valid_o && !ready));
  // R4: first appended bit is the top CRC bit
  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && ready && !load) |=> (bit_o == $past(crc[CRC_W-1])));
endmodule

// File: rtl/crcser_rx.sv
module crcser_rx #(
  parameter int unsigned   CRC_W  = 16,
  parameter int unsigned   BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev,
  input  logic              sof,
  input  logic              bit_valid,
  input  logic              bit_i,
  input  logic              eof,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid,
  output logic              crc_err
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] acc_q, acc_new, acc_rev, byte_q, byte_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bv_q, bv_d;
  logic              err_q, err_d;
  logic              last;
  logic              acc_en, byte_en, err_en;
  logic [CRC_W-1:0]  crc;

  crcser_crc_reg #(.CRC_W(CRC_W), .POLY(POLY), .PRESET(PRESET)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (sof),
    .step (bit_valid && !sof),
    .din  (bit_i),
    .crc  (crc)
  );

  always_comb begin
    acc_new        = acc_q;
    acc_new[cnt_q] = bit_i;
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign acc_rev[i] = acc_new[BYTE_W-1-i];
  end

  assign last    = (cnt_q == CNT_W'(BYTE_W - 1));
  assign acc_en  = sof || bit_valid;
  assign byte_en = bit_valid && last && !sof;
  assign err_en  = sof || eof;

  always_comb begin
    cnt_d  = cnt_q;
    if (sof) begin
      cnt_d = '0;
    end else if (bit_valid) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
    bv_d   = byte_en;
    byte_d = rev ? acc_rev : acc_new;
    err_d  = sof ? 1'b0 : (crc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      bv_q   <= 1'b0;
      byte_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bv_q <= bv_d;
      if (acc_en)  begin
        acc_q <= acc_new;
        cnt_q <= cnt_d;
      end
      if (byte_en) byte_q <= byte_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  assign byte_o     = byte_q;
  assign byte_valid = bv_q;
  assign crc_err    = err_q;

  // R5: a byte strobe always follows a received bit
  a_r5_byte_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_valid));
  // R8: frame start clears the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !crc_err);
  // R8: without strobes the flag holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !eof) |=> $stable(crc_err));
endmodule

// File: rtl/crcser_top.sv
module crcser_top
  import crcser_pkg::*;
#(
  parameter int unsigned   CRC_W  = DEF_CRC_W,
  parameter int unsigned   BYTE_W = DEF_BYTE_W,
  parameter logic [CRC_W-1:0] POLY   = DEF_POLY,
  parameter logic [CRC_W-1:0] PRESET = DEF_PRESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_order,
  input  logic              tx_sof,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_eof,
  output logic              tx_ready,
  output logic              tx_bit,
  output logic              tx_bit_valid,
  input  logic              rx_sof,
  input  logic              rx_bit,
  input  logic              rx_bit_valid,
  input  logic              rx_eof,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_valid,
  output logic              rx_crc_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  crcser_tx #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .PRESET(PRESET)) u_tx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rev    (rev_order),
    .sof    (tx_sof),
    .load   (tx_load),
    .data   (tx_data),
    .eof    (tx_eof),
    .ready  (tx_ready),
    .bit_o  (tx_bit),
    .valid_o(tx_bit_valid)
  );

  crcser_rx #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY), .PRESET(PRESET)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rev       (rev_order),
    .sof       (rx_sof),
    .bit_valid (rx_bit_valid),
    .bit_i     (rx_bit),
    .eof       (rx_eof),
    .byte_o    (rx_byte),
    .byte_valid(rx_byte_valid),
    .crc_err   (rx_crc_err)
  );

  // R9: while reset is held inside, outputs sit at their idle values
  a_r9_idle_in_reset: assert property (@(posedge clk)
    (rst_n && !rst_int_n) |-> (tx_ready && !tx_bit_valid && !rx_byte_valid && !rx_crc_err));
endmodule

// File: tb/test_crcser_top.sv
`timescale 1ns/1ps
module test_crcser_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rev_order = 1'b0;
  logic       tx_sof = 1'b0, tx_load = 1'b0, tx_eof = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, tx_bit, tx_bit_valid;
  logic       rx_sof = 1'b0, rx_eof = 1'b0;
  logic       rx_bit;
  logic [7:0] rx_byte;
  logic       rx_byte_valid, rx_crc_err;
  logic       flip_on = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int ncap = 0;
  int nrx = 0;
  logic       cap [0:255];
  logic [7:0] rxq [0:31];
  logic       expb [0:255];
  int         nexp;
  logic [7:0] frm [0:7];

  always #2.5 clk = ~clk;

  assign rx_bit = tx_bit ^ (flip_on && (ncap == 3));

  crcser_top i_crcser_top (
    .clk(clk), .rst_n(rst_n), .rev_order(rev_order),
    .tx_sof(tx_sof), .tx_load(tx_load), .tx_data(tx_data), .tx_eof(tx_eof),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid),
    .rx_sof(rx_sof), .rx_bit(rx_bit), .rx_bit_valid(tx_bit_valid), .rx_eof(rx_eof),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_crc_err(rx_crc_err)
  );

  always @(negedge clk) begin
    if (tx_bit_valid && ncap < 256) begin
      cap[ncap] = tx_bit;
      ncap = ncap + 1;
    end
    if (rx_byte_valid && nrx < 32) begin
      rxq[nrx] = rx_byte;
      nrx = nrx + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_fold(input logic [15:0] c, input logic b);
    logic f;
    f = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
  endfunction

  task automatic build_expected(input logic rev, input int n);
    logic [15:0] c;
    logic b;
    c = 16'hFFFF;
    nexp = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        b = rev ? frm[i][7-k] : frm[i][k];
        expb[nexp] = b;
        nexp++;
        c = crc_fold(c, b);
      end
    end
    for (int k = 15; k >= 0; k--) begin
      expb[nexp] = c[k];
      nexp++;
    end
  endtask

  task automatic run_frame(input logic rev, input int n, input logic flip);
    @(negedge clk);
    ncap = 0; nrx = 0; flip_on = flip; rev_order = rev;
    tx_sof = 1'b1; rx_sof = 1'b1;
    @(negedge clk);
    tx_sof = 1'b0; rx_sof = 1'b0;
    for (int i = 0; i < n; i++) begin
      while (!tx_ready) @(negedge clk);
      tx_load = 1'b1; tx_data = frm[i];
      @(negedge clk);
      tx_load = 1'b0;
    end
    while (!tx_ready) @(negedge clk);
    tx_eof = 1'b1;
    @(negedge clk);
    tx_eof = 1'b0;
    while (!tx_ready) @(negedge clk);
    rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
    flip_on = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 tx_ready", 32'(tx_ready), 32'd1);
    check("R9 tx_bit_valid", 32'(tx_bit_valid), 32'd0);
    check("R9 rx_byte_valid", 32'(rx_byte_valid), 32'd0);
    check("R9 rx_crc_err", 32'(rx_crc_err), 32'd0);
  endtask

  task automatic t_wire_order(input logic rev);
    int bad_data, bad_crc;
    frm[0] = 8'hB4;
    build_expected(rev, 1);
    run_frame(rev, 1, 1'b0);
    check(rev ? "R2 bit count rev1" : "R2 bit count rev0", 32'(ncap), 32'd24);
    bad_data = 0; bad_crc = 0;
    for (int k = 0; k < 8; k++) if (cap[k] !== expb[k]) bad_data++;
    for (int k = 8; k < 24; k++) if (cap[k] !== expb[k]) bad_crc++;
    check(rev ? "R3 data order rev1" : "R3 data order rev0", 32'(bad_data), 32'd0);
    check(rev ? "R4 R1 appended crc rev1" : "R4 R1 appended crc rev0", 32'(bad_crc), 32'd0);
  endtask

  task automatic t_loopback(input logic rev);
    int bad_bits;
    logic [7:0] pat [0:4];
    pat[0] = 8'h01; pat[1] = 8'h80; pat[2] = 8'h3C; pat[3] = 8'hFF; pat[4] = 8'hA6;
    for (int i = 0; i < 5; i++) frm[i] = pat[i];
    build_expected(rev, 5);
    run_frame(rev, 5, 1'b0);
    bad_bits = 0;
    for (int k = 0; k < nexp; k++) if (cap[k] !== expb[k]) bad_bits++;
    check(rev ? "R3 R4 frame bits rev1" : "R3 R4 frame bits rev0", 32'(bad_bits), 32'd0);
    check("R5 byte count", 32'(nrx), 32'd7);
    for (int i = 0; i < 5; i++)
      check(rev ? "R5 rx byte rev1" : "R5 rx byte rev0", 32'(rxq[i]), 32'(frm[i]));
    check(rev ? "R6 R7 clean residue rev1" : "R6 R7 clean residue rev0", 32'(rx_crc_err), 32'd0);
  endtask

  task automatic t_flip_and_clear;
    for (int i = 0; i < 3; i++) frm[i] = 8'h5A + 8'(i);
    run_frame(1'b1, 3, 1'b1);
    check("R7 flipped bit flags error", 32'(rx_crc_err), 32'd1);
    repeat (6) @(negedge clk);
    check("R8 error holds", 32'(rx_crc_err), 32'd1);
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
    check("R8 sof clears error", 32'(rx_crc_err), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wire_order(1'b0);
    t_wire_order(1'b1);
    t_loopback(1'b0);
    t_loopback(1'b1);
    t_flip_and_clear();
    t_loopback(1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule